// File: doc/BRIEF.md
# Memory Card Status Register

This block keeps the 32-bit status word that a memory card returns to its host. Each bit belongs to one of three families. The first family latches an event and is cleared when software reads the status. The second family reports a problem with the previous command and is cleared when the next valid command is accepted. The third family has no storage and follows the live card condition. The 4-bit current card state also shows in the word.

Command logic pulses per-bit event lines when it detects errors or status conditions. It pulses `rd_stb` when the status has been sent back to the host, and pulses `cmd_ok` when a command passes validation. The word on `status_word` is combinational, so in a strobe cycle it still shows the bits before they are cleared. The clear takes effect on the next clock edge. A second output packs the same information into the 16-bit serial-peripheral-mode status: the low byte is the short response and the high byte is the extended byte.

Top module: `card_status_reg`

## Requirements
- R1: After reset, every latching bit of `status_word` reads 0.
- R2: A 1 on `set_evt[i]` sets bit i, for any i in {31..26, 24..15, 13, 7, 5}. The bit then stays 1 until its own clear condition.
- R3: Bits 31..26, 24, 21..15, 13, 7 and 5 clear on the clock edge that ends a `rd_stb` cycle. In the strobe cycle itself, `status_word` still shows them set.
- R4: Bits 23 and 22 clear on the clock edge that ends a `cmd_ok` cycle. They are not cleared by `rd_stb`, and `cmd_ok` does not clear the bits listed in R3.
- R5: When a set event for a bit arrives in the same cycle as that bit's clear strobe, the bit stays 1.
- R6: Bit 25 equals `live_locked`, bit 14 equals `live_ecc_off`, bit 8 equals `live_ready`, and bits [12:9] equal `card_state`, all in the same cycle.
- R7: `set_evt` has no effect at positions 25, 14, 12..8, 6 and 4..0. Bits 6 and 4..0 always read 0.
- R8: `spi_status[7:0]` has these bits: bit 0 is 1 when `card_state` is 0 (idle), bit 1 is word bit 13, bit 2 is word bit 22, bit 3 is word bit 23, bit 4 is word bit 28, bit 5 is word bit 30, bit 6 is word bit 29, and bit 7 is 0.
- R9: `spi_status[15:8]` has these bits: bit 8 is word bit 25, bit 9 is word bit 15 OR 24, bit 10 is word bit 19, bit 11 is word bit 20, bit 12 is word bit 21, bit 13 is word bit 26, bit 14 is word bit 27, and bit 15 is word bit 31 OR 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 32 | Per-bit event pulses |
| card_state | input | 4 | Current card state |
| live_locked | input | 1 | Card locked condition |
| live_ecc_off | input | 1 | ECC disabled condition |
| live_ready | input | 1 | Ready for data condition |
| rd_stb | input | 1 | Status has been read |
| cmd_ok | input | 1 | A valid command was received |
| status_word | output | 32 | Native-mode status / response value |
| spi_status | output | 16 | Serial-mode status, short byte low |

## Verification
Two functions can fall in the same cycle: a set event and a clear of the same bit, where the clear comes from either a read strobe or an accepted command. Random stimulus pulses sparse event masks together with independent `rd_stb` and `cmd_ok` strobes, so these collisions occur often. Directed cycles also force them on chosen bits. A bench model updates once per clock edge. The word is judged before the edge, where it must show the pre-clear value, and again after the edge, where a colliding bit must still be 1 and only the bits that the active strobe owns may have dropped.

// File: rtl/card_status_reg.sv
module card_status_reg #(
  parameter int unsigned STATE_W    = 4,
  parameter logic [3:0]  IDLE_STATE = 4'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        set_evt,
  input  logic [STATE_W-1:0] card_state,
  input  logic               live_locked,
  input  logic               live_ecc_off,
  input  logic               live_ready,
  input  logic               rd_stb,
  input  logic               cmd_ok,
  output logic [31:0]        status_word,
  output logic [15:0]        spi_status
);

  localparam logic [31:0] RD_CLR_MASK  = 32'hFD3F_A0A0;
  localparam logic [31:0] CMD_CLR_MASK = 32'h00C0_0000;
  localparam logic [31:0] LATCH_MASK   = RD_CLR_MASK | CMD_CLR_MASK;

  logic [31:0] sticky_q;
  logic [31:0] clr_mask;
  logic [31:0] live_word;

  assign clr_mask = (rd_stb ? RD_CLR_MASK : 32'h0) | (cmd_ok ? CMD_CLR_MASK : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= ((sticky_q & ~clr_mask) | set_evt) & LATCH_MASK;
  end

  always_comb begin
    live_word       = '0;
    live_word[25]   = live_locked;
    live_word[14]   = live_ecc_off;
    live_word[8]    = live_ready;
    live_word[12:9] = card_state[3:0];
  end

  assign status_word = sticky_q | live_word;

  assign spi_status = {
    status_word[31] | status_word[16],
    status_word[27],
    status_word[26],
    status_word[21],
    status_word[20],
    status_word[19],
    status_word[24] | status_word[15],
    status_word[25],
    1'b0,
    status_word[29],
    status_word[30],
    status_word[28],
    status_word[23],
    status_word[22],
    status_word[13],
    card_state[3:0] == IDLE_STATE
  };

  // R3
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !cmd_ok) |=> ((status_word & RD_CLR_MASK & ~$past(set_evt)) == 32'h0));

  // R4
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> ((status_word & CMD_CLR_MASK & ~$past(set_evt)) == 32'h0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & LATCH_MASK) != 32'h0) |=>
      ((status_word & $past(set_evt & LATCH_MASK)) == $past(set_evt & LATCH_MASK)));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !cmd_ok) |=>
      ((status_word & $past(status_word & LATCH_MASK)) == $past(status_word & LATCH_MASK)));

  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[6] == 1'b0) && (status_word[4:0] == 5'd0));

endmodule

// File: tb/test_card_status_reg.sv
module test_card_status_reg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] set_evt = '0;
  logic [3:0]  card_state = '0;
  logic        live_locked = 0, live_ecc_off = 0, live_ready = 0;
  logic        rd_stb = 0, cmd_ok = 0;
  logic [31:0] status_word;
  logic [15:0] spi_status;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] m_sticky = '0;

  localparam logic [31:0] RDM  = (32'hF << 28) | (1 << 27) | (1 << 26) | (1 << 24) |
                                 (1 << 21) | (1 << 20) | (1 << 19) | (1 << 18) | (1 << 17) |
                                 (1 << 16) | (1 << 15) | (1 << 13) | (1 << 7) | (1 << 5);
  localparam logic [31:0] CMDM = (1 << 23) | (1 << 22);

  card_status_reg i_card_status_reg (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .card_state(card_state),
    .live_locked(live_locked), .live_ecc_off(live_ecc_off), .live_ready(live_ready),
    .rd_stb(rd_stb), .cmd_ok(cmd_ok), .status_word(status_word), .spi_status(spi_status)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = m_sticky;
    w[25] = live_locked;
    w[14] = live_ecc_off;
    w[8]  = live_ready;
    w[12:9] = card_state;
    return w;
  endfunction

  function automatic logic [15:0] exp_spi(input logic [31:0] w);
    logic [15:0] s;
    s = '0;
    s[0] = (card_state == 4'd0);
    s[1] = w[13]; s[2] = w[22]; s[3] = w[23]; s[4] = w[28];
    s[5] = w[30]; s[6] = w[29]; s[7] = 1'b0;
    s[8] = w[25]; s[9] = w[15] | w[24]; s[10] = w[19]; s[11] = w[20];
    s[12] = w[21]; s[13] = w[26]; s[14] = w[27]; s[15] = w[31] | w[16];
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [31:0] clr;
    clr = (rd_stb ? RDM : 32'h0) | (cmd_ok ? CMDM : 32'h0);
    @(posedge clk);
    m_sticky = ((m_sticky & ~clr) | set_evt) & (RDM | CMDM);
    @(negedge clk);
  endtask

  task automatic step(input logic [31:0] ev, input logic rd, input logic ck, input string tag);
    set_evt = ev; rd_stb = rd; cmd_ok = ck;
    #1;
    check({tag, " word"}, status_word, exp_word());
    check({tag, " spi"}, {16'h0, spi_status}, {16'h0, exp_spi(exp_word())});
    model_edge();
    set_evt = '0; rd_stb = 0; cmd_ok = 0;
    #1;
    check({tag, " after"}, status_word, exp_word());
  endtask

  initial begin
    #150000;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", status_word & (RDM | CMDM), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R7: events at non-latching positions ignored
    step(32'h0200_5F5F, 0, 0, "R7 ignored");
    check("R7 low bits", {26'h0, status_word[6], status_word[4:0]}, 32'h0);

    // R2: set all latching, hold without strobes
    step(RDM | CMDM, 0, 0, "R2 set");
    step(32'h0, 0, 0, "R2 hold");
    check("R2 all set", status_word & (RDM | CMDM), RDM | CMDM);

    // R4: read leaves bits 23/22
    step(32'h0, 1, 0, "R3 read");
    check("R4 read keeps cmd bits", status_word & (RDM | CMDM), CMDM);

    // R4: cmd_ok clears 23/22 but not read-clear bits
    step(RDM, 0, 0, "R2 reset rc");
    step(32'h0, 0, 1, "R4 cmd");
    check("R4 cmd keeps rc bits", status_word & (RDM | CMDM), RDM);

    // R5: set with read, set with cmd
    step(32'h8000_0020, 1, 0, "R5 set+read");
    check("R5 read collision", status_word & (RDM | CMDM), 32'h8000_0020);
    step(32'h0040_0000, 0, 1, "R5 set+cmd");
    check("R5 cmd collision", status_word[23:22], 32'h1);

    // R6 / R8 / R9: live fields and SPI mapping
    live_locked = 1; live_ecc_off = 1; live_ready = 1; card_state = 4'd9;
    step(32'h0, 0, 0, "R6 live");
    check("R6 state field", {28'h0, status_word[12:9]}, 32'd9);
    card_state = 4'd0;
    step(32'hFFFF_FFFF, 0, 0, "R8 R9 spi full");
    check("R8 idle", {31'h0, spi_status[0]}, 32'h1);
    check("R9 high byte", {24'h0, spi_status[15:8]}, 32'hFF);

    for (int k = 0; k < 3000; k++) begin
      card_state   = 4'($urandom);
      live_locked  = 1'($urandom);
      live_ecc_off = 1'($urandom);
      live_ready   = 1'($urandom);
      step($urandom & $urandom & $urandom, ($urandom % 4) == 0, ($urandom % 4) == 0,
           "R2 R3 R4 R5 R6 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule